// File: doc/BRIEF.md
# Page Entry Access Gate with Reference/Change Update

This block takes a leaf page table entry that a table walker has just read and decides whether a requested load, store or instruction fetch may use it. It works out the read/write/execute rights granted to the access, raises a fault with a cause code when the access is refused, and builds a copy of the entry with the referenced bit and, for stores, the changed bit set. When that copy differs from the entry that was read, and the access is visible to the guest, the block asks for the copy to be written back to memory through a request/acknowledge port.

A walker pulses `start` with the entry, its memory address and the access attributes. The block captures them, evaluates the entry on the next edge and either ends at once with a one-cycle `done` pulse or first holds a write request until memory acknowledges it. Write permission is never granted to a non-store access, so a later store to the same page always comes back through this block and gets the changed bit set. The sequencer has four states: IDLE (waits for `start`), EVAL (registers the verdict and updated entry), WRITE (holds the write-back request) and DONE (pulses `done`). The transitions are IDLE to EVAL on `start`, EVAL to WRITE when a write-back is needed, EVAL to DONE when it is not, WRITE to DONE on `wb_ack`, and DONE to IDLE unconditionally.

Entry bit positions used throughout: bit 0 execute right, bit 1 write right, bit 2 read right, bit 3 privileged page, bits 5:4 memory attribute (value 2 is non-idempotent I/O), bit 7 changed, bit 8 referenced. Rights vectors (`grant_perm`, `amr_perm`) use bit 2 read, bit 1 write, bit 0 execute. Access codes: 0 load, 1 store, 2 fetch, 3 behaves as a load.

Top module: `pte_access_gate`

## Requirements
- R1: A fetch (code 2) of an entry whose attribute field (bits 5:4) equals 2 faults with cause value 1 (guarded no-execute) and no rights are granted, whatever the other entry bits and flags.
- R2: When `part_scoped` is 0, the privileged bit (bit 3) is 1 and `cpu_user` is 1, the raw rights are empty.
- R3: Otherwise, when `idx_user`, the privileged bit or `part_scoped` is 1, the raw rights are the entry's rights bits {bit 2, bit 1, bit 0}.
- R4: In all remaining cases the raw rights are the entry's rights bits ANDed with `amr_perm`.
- R5: An access faults when its required right (read for load and code 3, write for store, execute for fetch) is absent from the raw rights; the cause is 1 for a fetch and 2 for a load or store, and `grant_perm` is 0 on any fault.
- R6: Without a fault, `upd_pte` is the entry with bit 8 set, and bit 7 also set only for a store; with a fault `upd_pte` equals the entry unchanged.
- R7: Without a fault, `grant_perm` is the raw rights, with the write right cleared for every access that is not a store.
- R8: A write-back of `upd_pte` to `pte_addr` is requested only when `upd_pte` differs from the entry.
- R9: No write-back is requested when the access faults or `guest_visible` is 0.
- R10: With no write-back, `done` is high for one cycle starting on the second clock edge after `start`; with a write-back, `wb_req` rises on that edge, `wb_addr` and `wb_data` stay stable while it waits, and `done` follows on the edge that samples `wb_ack`, with `wb_req` dropped.
- R11: After reset `done`, `wb_req`, `fault`, `fault_cause`, `grant_perm` and `upd_pte` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a check; inputs captured on this edge when idle |
| pte_in | input | 64 | Leaf entry as read from memory |
| pte_addr | input | 52 | Memory address of the entry |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 as load |
| cpu_user | input | 1 | CPU is in problem (user) state |
| idx_user | input | 1 | Access index is a user index |
| part_scoped | input | 1 | Check belongs to the partition-scoped stage |
| amr_perm | input | 3 | Rights allowed by the authority mask, {read, write, execute} |
| guest_visible | input | 1 | Side effects (write-back) permitted |
| wb_ack | input | 1 | Memory accepts the write-back |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | 52 | Write-back address |
| wb_data | output | 64 | Write-back data |
| done | output | 1 | One-cycle completion pulse; results valid |
| fault | output | 1 | Access refused |
| fault_cause | output | 2 | 1 guarded no-execute, 2 protection fault |
| grant_perm | output | 3 | Granted rights, {read, write, execute} |
| upd_pte | output | 64 | Entry with referenced/changed bits applied |

## Verification
The hardest case to reach is the mask-combined rights path, which only applies when the check is process-scoped, the access index is not a user index and the page is not privileged; a separate sweep pins those three flags low and walks every mask value against every rights combination and access code. The write-back path needs an entry whose referenced or changed bit is still clear together with a passing access and a visible guest, so the main sweep covers every combination of both bits with every flag setting and varies the acknowledge delay from zero to two cycles, checking address and data on each waiting cycle.

// File: rtl/pte_gate_pkg.sv
package pte_gate_pkg;
    localparam int PTE_W    = 64;
    localparam int PERM_W   = 3;
    localparam int CAUSE_W  = 2;

    // Entry field positions
    localparam int BIT_X    = 0;
    localparam int BIT_W    = 1;
    localparam int BIT_R    = 2;
    localparam int BIT_PRIV = 3;
    localparam int ATT_LO   = 4;
    localparam int ATT_HI   = 5;
    localparam int BIT_CHG  = 7;
    localparam int BIT_REF  = 8;

    localparam logic [1:0] ATT_NIO = 2'd2;

    // Rights vector positions
    localparam int P_R = 2;
    localparam int P_W = 1;
    localparam int P_X = 0;

    // Fault cause values
    localparam logic [CAUSE_W-1:0] CAUSE_NONE   = 2'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_NOEXEC = 2'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_PROT   = 2'd2;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } seq_e;
endpackage

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
    import pte_gate_pkg::*;
(
    input  logic [PERM_W-1:0]  rights,
    input  logic               priv_pg,
    input  logic [1:0]         attr,
    input  acc_e               acc,
    input  logic               cpu_user,
    input  logic               idx_user,
    input  logic               part_scoped,
    input  logic [PERM_W-1:0]  amr_perm,
    output logic [PERM_W-1:0]  grant,
    output logic               fault,
    output logic [CAUSE_W-1:0] cause
);
    logic [PERM_W-1:0] raw;
    logic [PERM_W-1:0] need;
    logic              nio_fetch;

    assign nio_fetch = (attr == ATT_NIO) && (acc == ACC_FETCH);

    always_comb begin
        if (!part_scoped && priv_pg && cpu_user)
            raw = '0;
        else if (idx_user || priv_pg || part_scoped)
            raw = rights;
        else
            raw = rights & amr_perm;
    end

    always_comb begin
        need = '0;
        unique case (acc)
            ACC_STORE: need[P_W] = 1'b1;
            ACC_FETCH: need[P_X] = 1'b1;
            ACC_LOAD,
            ACC_RSVD:  need[P_R] = 1'b1;
        endcase
    end

    always_comb begin
        fault = 1'b0;
        cause = CAUSE_NONE;
        grant = '0;
        if (nio_fetch) begin
            fault = 1'b1;
            cause = CAUSE_NOEXEC;
        end else if ((need & ~raw) != '0) begin
            fault = 1'b1;
            cause = (acc == ACC_FETCH) ? CAUSE_NOEXEC : CAUSE_PROT;
        end else begin
            grant = raw;
            if (acc != ACC_STORE)
                grant[P_W] = 1'b0;
        end
    end

    // R5
    always_comb begin
        cause_onehot_chk: assert ($onehot0(cause))
            else $error("cause has more than one bit set");
    end
endmodule

// File: rtl/pte_rc_merge.sv
module pte_rc_merge
    import pte_gate_pkg::*;
(
    input  logic [PTE_W-1:0] entry,
    input  acc_e             acc,
    input  logic             fault,
    output logic [PTE_W-1:0] merged,
    output logic             changed
);
    always_comb begin
        merged = entry;
        if (!fault) begin
            merged[BIT_REF] = 1'b1;
            if (acc == ACC_STORE)
                merged[BIT_CHG] = 1'b1;
        end
    end

    assign changed = (merged != entry);
endmodule

// File: rtl/pte_wb_seq.sv
module pte_wb_seq
    import pte_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic need_wb,
    input  logic wb_ack,
    output logic cap_en,
    output logic res_en,
    output logic wb_req,
    output logic done
);
    seq_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)  state_nx = ST_EVAL;
            ST_EVAL:  state_nx = need_wb ? ST_WRITE : ST_DONE;
            ST_WRITE: if (wb_ack) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        cap_en = (state == ST_IDLE) && start;
        res_en = (state == ST_EVAL);
        wb_req = (state == ST_WRITE);
        done   = (state == ST_DONE);
    end

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> wb_req)
        else $error("write request dropped before ack");

    // R10
    done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && wb_ack |=> done && !wb_req)
        else $error("done did not follow ack");

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");
endmodule

// File: rtl/pte_access_gate.sv
module pte_access_gate
    import pte_gate_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [PTE_W-1:0]    pte_in,
    input  logic [PA_W-1:0]     pte_addr,
    input  logic [1:0]          acc_type,
    input  logic                cpu_user,
    input  logic                idx_user,
    input  logic                part_scoped,
    input  logic [PERM_W-1:0]   amr_perm,
    input  logic                guest_visible,
    input  logic                wb_ack,
    output logic                wb_req,
    output logic [PA_W-1:0]     wb_addr,
    output logic [PTE_W-1:0]    wb_data,
    output logic                done,
    output logic                fault,
    output logic [CAUSE_W-1:0]  fault_cause,
    output logic [PERM_W-1:0]   grant_perm,
    output logic [PTE_W-1:0]    upd_pte
);
    // Captured request
    logic [PTE_W-1:0]  ent_q;
    logic [PA_W-1:0]   addr_q;
    acc_e              acc_q;
    logic              cu_q, iu_q, ps_q, gv_q;
    logic [PERM_W-1:0] amr_q;

    // Evaluation results
    logic [PERM_W-1:0]  grant_c;
    logic               fault_c;
    logic [CAUSE_W-1:0] cause_c;
    logic [PTE_W-1:0]   merged_c;
    logic               changed_c;
    logic               need_wb;
    logic               cap_en, res_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_q  <= '0;
            addr_q <= '0;
            acc_q  <= ACC_LOAD;
            cu_q   <= 1'b0;
            iu_q   <= 1'b0;
            ps_q   <= 1'b0;
            gv_q   <= 1'b0;
            amr_q  <= '0;
        end else if (cap_en) begin
            ent_q  <= pte_in;
            addr_q <= pte_addr;
            acc_q  <= acc_e'(acc_type);
            cu_q   <= cpu_user;
            iu_q   <= idx_user;
            ps_q   <= part_scoped;
            gv_q   <= guest_visible;
            amr_q  <= amr_perm;
        end
    end

    pte_perm_eval u_eval (
        .rights      ({ent_q[BIT_R], ent_q[BIT_W], ent_q[BIT_X]}),
        .priv_pg     (ent_q[BIT_PRIV]),
        .attr        (ent_q[ATT_HI:ATT_LO]),
        .acc         (acc_q),
        .cpu_user    (cu_q),
        .idx_user    (iu_q),
        .part_scoped (ps_q),
        .amr_perm    (amr_q),
        .grant       (grant_c),
        .fault       (fault_c),
        .cause       (cause_c)
    );

    pte_rc_merge u_merge (
        .entry   (ent_q),
        .acc     (acc_q),
        .fault   (fault_c),
        .merged  (merged_c),
        .changed (changed_c)
    );

    assign need_wb = changed_c && !fault_c && gv_q;

    pte_wb_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .need_wb (need_wb),
        .wb_ack  (wb_ack),
        .cap_en  (cap_en),
        .res_en  (res_en),
        .wb_req  (wb_req),
        .done    (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault       <= 1'b0;
            fault_cause <= CAUSE_NONE;
            grant_perm  <= '0;
            upd_pte     <= '0;
        end else if (res_en) begin
            fault       <= fault_c;
            fault_cause <= cause_c;
            grant_perm  <= grant_c;
            upd_pte     <= merged_c;
        end
    end

    assign wb_addr = addr_q;
    assign wb_data = upd_pte;

    // R10
    wb_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> $stable(wb_addr) && $stable(wb_data))
        else $error("write-back address or data moved while waiting");

    // R9
    no_wb_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !fault && gv_q)
        else $error("write-back with fault or hidden guest");

    // R7
    no_write_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && (acc_q != ACC_STORE) |-> !grant_perm[P_W])
        else $error("write right granted to a non-store");

    // R6
    ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !fault |-> upd_pte[BIT_REF])
        else $error("referenced bit missing after passing check");

    // R8
    wb_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (wb_data != ent_q))
        else $error("write-back of an unchanged entry");
endmodule

// File: tb/tb_pte_access_gate.sv
module tb_pte_access_gate;
    localparam int PA_W = 52;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [63:0]      pte_in = '0;
    logic [PA_W-1:0]  pte_addr = '0;
    logic [1:0]       acc_type = '0;
    logic             cpu_user = 1'b0, idx_user = 1'b0, part_scoped = 1'b0;
    logic [2:0]       amr_perm = '0;
    logic             guest_visible = 1'b0;
    logic             wb_ack = 1'b0;
    logic             wb_req, done, fault;
    logic [PA_W-1:0]  wb_addr;
    logic [63:0]      wb_data, upd_pte;
    logic [1:0]       fault_cause;
    logic [2:0]       grant_perm;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    pte_access_gate #(.PA_W(PA_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pte_in(pte_in),
        .pte_addr(pte_addr), .acc_type(acc_type), .cpu_user(cpu_user),
        .idx_user(idx_user), .part_scoped(part_scoped), .amr_perm(amr_perm),
        .guest_visible(guest_visible), .wb_ack(wb_ack), .wb_req(wb_req),
        .wb_addr(wb_addr), .wb_data(wb_data), .done(done), .fault(fault),
        .fault_cause(fault_cause), .grant_perm(grant_perm), .upd_pte(upd_pte)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic run(input logic [63:0] e, input logic [1:0] acc, input bit cu,
                       input bit iu, input bit ps, input logic [2:0] amr,
                       input bit gv, input logic [PA_W-1:0] addr, input int dly);
        logic [2:0] aa, raw, need, eg;
        bit         ef, ewb;
        logic [1:0] ec;
        logic [63:0] eu;
        int         cyc;
        bit         saw;
        aa = {e[2], e[1], e[0]};
        ef = 1'b0; ec = 2'd0; eg = 3'd0;
        if (e[3] && cu && !ps)         raw = 3'd0;
        else if (iu || e[3] || ps)     raw = aa;
        else                           raw = aa & amr;
        need = (acc == 2'd1) ? 3'b010 : (acc == 2'd2) ? 3'b001 : 3'b100;
        if (acc == 2'd2 && e[5:4] == 2'd2) begin
            ef = 1'b1; ec = 2'd1;                        // R1
        end else if ((need & ~raw) != 3'd0) begin
            ef = 1'b1; ec = (acc == 2'd2) ? 2'd1 : 2'd2; // R5
        end else begin
            eg = (acc == 2'd1) ? raw : (raw & 3'b101);   // R2 R3 R4 R7
        end
        eu = e;
        if (!ef) begin
            eu[8] = 1'b1;
            if (acc == 2'd1) eu[7] = 1'b1;
        end
        ewb = !ef && gv && (eu != e);

        @(negedge clk);
        pte_in = e; acc_type = acc; cpu_user = cu; idx_user = iu;
        part_scoped = ps; amr_perm = amr; guest_visible = gv; pte_addr = addr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        pte_in = ~e; amr_perm = ~amr; pte_addr = ~addr;
        @(negedge clk);
        cyc = 0; saw = 1'b0;
        while (!done && cyc < 40) begin
            if (wb_req) begin
                saw = 1'b1;
                chk(wb_addr == addr, "R10 wb_addr", longint'(wb_addr), longint'(addr));
                chk(wb_data == eu, "R8 wb_data", wb_data, eu);
                if (cyc == dly) wb_ack = 1'b1;
            end
            @(negedge clk);
            wb_ack = 1'b0;
            cyc++;
        end
        chk(done, "R10 done seen", longint'(done), 1);
        chk(cyc == (ewb ? dly + 1 : 0), "R10 done timing", cyc, ewb ? dly + 1 : 0);
        chk(!wb_req, "R10 wb_req low at done", longint'(wb_req), 0);
        chk(saw == ewb, "R8 R9 write-back request", longint'(saw), longint'(ewb));
        chk(fault == ef, "R5 fault", longint'(fault), longint'(ef));
        chk(fault_cause == ec, "R1 R5 cause", longint'(fault_cause), longint'(ec));
        chk(grant_perm == eg, "R2 R3 R4 R7 grant", longint'(grant_perm), longint'(eg));
        chk(upd_pte == eu, "R6 updated entry", upd_pte, eu);
        @(negedge clk);
        chk(!done, "R10 done single cycle", longint'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11
        chk(done == 0 && wb_req == 0, "R11 handshake idle", longint'({done, wb_req}), 0);
        chk(fault == 0 && fault_cause == 0, "R11 fault clear", longint'({fault, fault_cause}), 0);
        chk(grant_perm == 0 && upd_pte == 0, "R11 results clear", upd_pte, 0);
        rst_n = 1'b1;

        // Main sweep: all low entry bits, REF/CHG, access codes, flags
        for (int i = 0; i < 256; i++) begin
            for (int a = 0; a < 3; a++) begin
                for (int f = 0; f < 8; f++) begin
                    logic [63:0] e;
                    e = {24'hA5C3_1F, 31'h0, i[7], i[6], 1'b0, i[5:0]};
                    e[63:40] = 24'hA5C31F ^ 24'(i);
                    run(e, 2'(a), f[0], f[1], f[2], 3'b101,
                        ((i + f + a) % 5) != 0, PA_W'(64'h1000 + i * 8 + f), (i + a) % 3);
                end
            end
        end

        // Mask-combined path: every mask against every rights set (R4)
        for (int m = 0; m < 8; m++) begin
            for (int r = 0; r < 8; r++) begin
                for (int a = 0; a < 4; a++) begin
                    run({56'h0, 1'b1, 1'b1, 6'(r)}, 2'(a), 1'b0, 1'b0, 1'b0,
                        3'(m), 1'b1, PA_W'(64'h2000 + m * 64 + r), 1);
                end
            end
        end

        // Hidden guest: changes needed but no write-back (R9)
        for (int a = 0; a < 4; a++)
            run(64'h7, 2'(a), 1'b0, 1'b1, 1'b0, 3'b111, 1'b0, PA_W'(64'h3000), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule